// File: doc/BRIEF.md
# RTC-Style Interrupt Flag Generator

This block reproduces the three interrupt sources of a classic real-time clock (periodic, alarm and update-ended) on top of a free-running counter. It does not keep time itself. The system supplies the counter value and the current hours, minutes and seconds. The block keeps its own compare point on that counter and services a "tick" every time the counter reaches it. On each serviced tick it decides which events qualify. When at least one does, it registers a flag word and pulses an interrupt strobe.

The tick interval is a base period of `BASE_DELTA = 2**BASE_SHIFT` counts, which corresponds to a 64 Hz poll. Update and alarm events are found by polling at that rate. When the periodic source asks for a rate above 64 Hz, the interval shrinks to the requested period and every tick is periodic. At or below 64 Hz, a divider counts base ticks. If the counter has moved past several compare points, the tick catches up in a single cycle. The compare points it skipped count as lost ticks and are fed into the periodic divider.

Top module: `rtc_irq_flaggen`

## Requirements
- R1: While and after reset, `flag_word_o`, `irq_o` and `tick_o` are all 0.
- R2: When any enable goes high while all three were low at the previous clock edge, the compare point is set to `now_cnt` plus one interval. A tick is serviced at the first edge where `now_cnt - compare` is non-negative as a signed `CNT_W`-bit value. `tick_o` is high for the single cycle after that edge.
- R3: The requested rate is 2^`rate_log2` Hz. Codes below 1 act as 1 and codes above 13 act as 13. The interval is `BASE_DELTA` counts. The exception is when the periodic enable is set and the rate is above 64 Hz: the interval is then `BASE_DELTA >> (rate_log2 - 6)`.
- R4: On a serviced tick, the compare point advances by (L+1) intervals, where L = floor((`now_cnt` - compare) / interval). L is the lost-tick count.
- R5: For a rate at or below 64 Hz, the periodic counter adds L+1 on each tick. When the sum reaches 2^(6-`rate_log2`) or more, the periodic flag is raised and the counter returns to 0. The counter is held at 0 while the periodic enable is low.
- R6: For a rate above 64 Hz with the periodic enable set, every serviced tick raises the periodic flag.
- R7: With the update enable set, a tick raises the update flag when `tod_sec` differs from the recorded second. The first tick after the enable rises only records the second and raises nothing.
- R8: With the alarm enable set, a tick raises the alarm flag when hours, minutes and seconds all equal the alarm inputs.
- R9: Flag word layout: bit 4 update, bit 5 alarm, bit 6 periodic, bit 7 interrupt pending, bits 15:8 = 1, all other bits 0. Bit 7 and bits 15:8 are set only when at least one event bit is set. A tick with no qualifying event loads 0.
- R10: `irq_o` is a single-cycle pulse in the cycle the flag word is loaded with events. The flag word changes only in cycles where `tick_o` is high.
- R11: While all three enables are low, no tick is serviced and the flag word holds its value. Re-enabling restarts the schedule from the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_cnt | input | CNT_W | Free-running counter value |
| tod_hr | input | HR_W | Current hours |
| tod_min | input | MS_W | Current minutes |
| tod_sec | input | MS_W | Current seconds |
| en_update | input | 1 | Update event enable |
| en_alarm | input | 1 | Alarm event enable |
| en_periodic | input | 1 | Periodic event enable |
| alm_hr | input | HR_W | Alarm hours |
| alm_min | input | MS_W | Alarm minutes |
| alm_sec | input | MS_W | Alarm seconds |
| rate_log2 | input | RATE_W | Periodic rate as log2 of Hz |
| flag_word_o | output | 16 | Registered flag word |
| irq_o | output | 1 | Interrupt strobe |
| tick_o | output | 1 | Tick-serviced strobe |

## Verification
The hardest situation to reach is a multi-interval catch-up. It needs the counter to skip several compare points in one clock, while the periodic divider holds a partial count, and sometimes while the counter crosses its wrap point. The bench drives the counter directly. It adds small random steps, with occasional jumps of thousands of counts, and starts just below the wrap value. Lost-tick sums, divider rollovers and wrap-around comparisons therefore all occur during the random phase. A directed prologue first pins down exact cycles for the first-record rule, an exact catch-up and a mid-run switch between fast and slow rates.

// File: rtl/rtcfg_pkg.sv
package rtcfg_pkg;
   localparam int FLAG_W   = 16;
   localparam int UF_POS   = 4;
   localparam int AF_POS   = 5;
   localparam int PF_POS   = 6;
   localparam int IRQF_POS = 7;
   localparam int NUM_LSB  = 8;
   localparam logic [7:0] INT_COUNT = 8'd1;

   typedef struct packed {
      logic pf;
      logic af;
      logic uf;
   } evt_t;

   function automatic logic [FLAG_W-1:0] pack_flags(input evt_t e);
      logic [FLAG_W-1:0] w;
      w = '0;
      if (e.uf | e.af | e.pf) begin
         w[UF_POS]   = e.uf;
         w[AF_POS]   = e.af;
         w[PF_POS]   = e.pf;
         w[IRQF_POS] = 1'b1;
         w[NUM_LSB +: 8] = INT_COUNT;
      end
      return w;
   endfunction
endpackage

// File: rtl/rtcfg_tick_sched.sv
module rtcfg_tick_sched #(
   parameter int CNT_W      = 32,
   parameter int BASE_SHIFT = 8,
   parameter int RATE_W     = 4,
   parameter int BASE_LOG2  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_en,
   input  logic              fast,
   input  logic [RATE_W-1:0] sel,
   input  logic [CNT_W-1:0]  now,
   output logic              hit,
   output logic [CNT_W-1:0]  lost
);
   localparam int SH_W = $clog2(BASE_SHIFT + 1);

   logic             armed, prev_any;
   logic [CNT_W-1:0] cmp, diff, delta, adv;
   logic [SH_W-1:0]  dsh;

   always_comb begin
      if (fast) dsh = SH_W'(BASE_SHIFT) - SH_W'(sel - RATE_W'(BASE_LOG2));
      else      dsh = SH_W'(BASE_SHIFT);
      delta = CNT_W'(1) << dsh;
      diff  = now - cmp;
      hit   = armed && any_en && prev_any && !diff[CNT_W-1];
      lost  = diff >> dsh;
      adv   = (lost + CNT_W'(1)) << dsh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         prev_any <= 1'b0;
         cmp      <= '0;
      end else begin
         prev_any <= any_en;
         if (!any_en) begin
            armed <= 1'b0;
         end else if (!prev_any) begin
            armed <= 1'b1;
            cmp   <= now + delta;
         end else if (hit) begin
            cmp <= cmp + adv;
         end
      end
   end
endmodule

// File: rtl/rtcfg_rate_div.sv
module rtcfg_rate_div #(
   parameter int CNT_W     = 32,
   parameter int RATE_W    = 4,
   parameter int BASE_LOG2 = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_p,
   input  logic              hit,
   input  logic              fast,
   input  logic [RATE_W-1:0] sel,
   input  logic [CNT_W-1:0]  lost,
   output logic              pf
);
   localparam int PC_W  = BASE_LOG2 + 1;
   localparam int SUM_W = CNT_W + 1;

   logic [PC_W-1:0]  pcnt, lim;
   logic [SUM_W-1:0] sum;

   always_comb begin
      if (fast) lim = PC_W'(1);
      else      lim = PC_W'(1) << (RATE_W'(BASE_LOG2) - sel);
      sum = SUM_W'(lost) + SUM_W'(pcnt) + SUM_W'(1);
      pf  = en_p && hit && (sum >= SUM_W'(lim));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt <= '0;
      else if (!en_p)   pcnt <= '0;
      else if (hit)     pcnt <= pf ? '0 : sum[PC_W-1:0];
   end
endmodule

// File: rtl/rtcfg_update_det.sv
module rtcfg_update_det #(
   parameter int MS_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_u,
   input  logic            hit,
   input  logic [MS_W-1:0] sec,
   output logic            uf
);
   logic            seen;
   logic [MS_W-1:0] last_sec;
   logic            changed;

   assign changed = !seen || (sec != last_sec);
   assign uf      = en_u && hit && changed && seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen     <= 1'b0;
         last_sec <= '0;
      end else if (!en_u) begin
         seen <= 1'b0;
      end else if (hit && changed) begin
         seen     <= 1'b1;
         last_sec <= sec;
      end
   end
endmodule

// File: rtl/rtc_irq_flaggen.sv
module rtc_irq_flaggen #(
   parameter int CNT_W      = 32,
   parameter int HR_W       = 5,
   parameter int MS_W       = 6,
   parameter int RATE_W     = 4,
   parameter int BASE_SHIFT = 8,
   parameter int BASE_LOG2  = 6,
   parameter int MIN_LOG2   = 1,
   parameter int MAX_LOG2   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  now_cnt,
   input  logic [HR_W-1:0]   tod_hr,
   input  logic [MS_W-1:0]   tod_min,
   input  logic [MS_W-1:0]   tod_sec,
   input  logic              en_update,
   input  logic              en_alarm,
   input  logic              en_periodic,
   input  logic [HR_W-1:0]   alm_hr,
   input  logic [MS_W-1:0]   alm_min,
   input  logic [MS_W-1:0]   alm_sec,
   input  logic [RATE_W-1:0] rate_log2,
   output logic [15:0]       flag_word_o,
   output logic              irq_o,
   output logic              tick_o
);
   import rtcfg_pkg::*;

   if (BASE_SHIFT < MAX_LOG2 - BASE_LOG2) begin : g_bad_shift
      $error("BASE_SHIFT too small for the fastest periodic rate");
   end
   if (MAX_LOG2 >= (1 << RATE_W)) begin : g_bad_rate_w
      $error("RATE_W cannot encode MAX_LOG2");
   end
   if (CNT_W < BASE_SHIFT + 2) begin : g_bad_cnt_w
      $error("CNT_W must exceed the base interval width");
   end
   if (MIN_LOG2 < 1 || MIN_LOG2 > BASE_LOG2) begin : g_bad_min
      $error("MIN_LOG2 out of range");
   end

   logic [RATE_W-1:0] sel;
   logic              any_en, fast, hit;
   logic [CNT_W-1:0]  lost;
   evt_t              ev;

   always_comb begin
      if (rate_log2 < RATE_W'(MIN_LOG2))      sel = RATE_W'(MIN_LOG2);
      else if (rate_log2 > RATE_W'(MAX_LOG2)) sel = RATE_W'(MAX_LOG2);
      else                                    sel = rate_log2;
   end

   assign any_en = en_update | en_alarm | en_periodic;
   assign fast   = en_periodic && (sel > RATE_W'(BASE_LOG2));

   rtcfg_tick_sched #(
      .CNT_W(CNT_W), .BASE_SHIFT(BASE_SHIFT), .RATE_W(RATE_W), .BASE_LOG2(BASE_LOG2)
   ) u_sched (
      .clk(clk), .rst_n(rst_n), .any_en(any_en), .fast(fast), .sel(sel),
      .now(now_cnt), .hit(hit), .lost(lost)
   );

   rtcfg_rate_div #(
      .CNT_W(CNT_W), .RATE_W(RATE_W), .BASE_LOG2(BASE_LOG2)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .en_p(en_periodic), .hit(hit), .fast(fast),
      .sel(sel), .lost(lost), .pf(ev.pf)
   );

   rtcfg_update_det #(.MS_W(MS_W)) u_upd (
      .clk(clk), .rst_n(rst_n), .en_u(en_update), .hit(hit), .sec(tod_sec), .uf(ev.uf)
   );

   assign ev.af = en_alarm && hit && (tod_hr == alm_hr) &&
                  (tod_min == alm_min) && (tod_sec == alm_sec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_word_o <= '0;
         irq_o       <= 1'b0;
         tick_o      <= 1'b0;
      end else begin
         tick_o <= hit;
         irq_o  <= hit && (ev.uf | ev.af | ev.pf);
         if (hit) flag_word_o <= pack_flags(ev);
      end
   end
endmodule

// File: rtl/rtcfg_chk.sv
module rtcfg_chk #(
   parameter int HR_W     = 5,
   parameter int MS_W     = 6,
   parameter int RATE_W   = 4,
   parameter int BASE_LOG2 = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_update,
   input logic              en_alarm,
   input logic              en_periodic,
   input logic [RATE_W-1:0] rate_log2,
   input logic [HR_W-1:0]   tod_hr,
   input logic [MS_W-1:0]   tod_min,
   input logic [MS_W-1:0]   tod_sec,
   input logic [HR_W-1:0]   alm_hr,
   input logic [MS_W-1:0]   alm_min,
   input logic [MS_W-1:0]   alm_sec,
   input logic [15:0]       flag_word_o,
   input logic              irq_o,
   input logic              tick_o
);
   // R10
   irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> tick_o);

   // R10
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_o |-> $stable(flag_word_o));

   // R9
   word_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flag_word_o[15:8] == 8'd1 && flag_word_o[7] && flag_word_o[3:0] == 4'd0));

   // R9
   no_irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && !irq_o) |-> (flag_word_o == 16'd0));

   // R11
   idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!en_update && !en_alarm && !en_periodic) |-> !tick_o);

   // R6
   fast_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && $past(en_periodic && rate_log2 > RATE_W'(BASE_LOG2))) |-> flag_word_o[6]);

   // R8
   alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && $past(en_alarm && tod_hr == alm_hr && tod_min == alm_min &&
                       tod_sec == alm_sec)) |-> flag_word_o[5]);
endmodule

bind rtc_irq_flaggen rtcfg_chk #(
   .HR_W(HR_W), .MS_W(MS_W), .RATE_W(RATE_W), .BASE_LOG2(BASE_LOG2)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en_update(en_update), .en_alarm(en_alarm),
   .en_periodic(en_periodic), .rate_log2(rate_log2), .tod_hr(tod_hr),
   .tod_min(tod_min), .tod_sec(tod_sec), .alm_hr(alm_hr), .alm_min(alm_min),
   .alm_sec(alm_sec), .flag_word_o(flag_word_o), .irq_o(irq_o), .tick_o(tick_o)
);

// File: tb/tb_rtc_irq_flaggen.sv
module tb_rtc_irq_flaggen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] now = 32'd0;
   logic [4:0]  hr = 5'd1, ahr = 5'd0;
   logic [5:0]  mn = 6'd2, amn = 6'd0;
   logic [5:0]  sec = 6'd5, asec = 6'd0;
   logic        en_u = 1'b0, en_a = 1'b0, en_p = 1'b0;
   logic [3:0]  rate = 4'd0;
   logic [15:0] word;
   logic        irq, tick;

   int checks = 0;
   int fails  = 0;

   // model state
   logic [31:0] m_cmp = 32'd0;
   logic        m_armed = 1'b0, m_prev_any = 1'b0, m_seen = 1'b0;
   logic [5:0]  m_psec = 6'd0;
   longint      m_pcnt = 0;
   logic [15:0] e_word = 16'd0;
   logic        e_irq = 1'b0, e_tick = 1'b0;

   always #5 clk = ~clk;

   rtc_irq_flaggen dut (
      .clk(clk), .rst_n(rst_n), .now_cnt(now), .tod_hr(hr), .tod_min(mn),
      .tod_sec(sec), .en_update(en_u), .en_alarm(en_a), .en_periodic(en_p),
      .alm_hr(ahr), .alm_min(amn), .alm_sec(asec), .rate_log2(rate),
      .flag_word_o(word), .irq_o(irq), .tick_o(tick)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit          any, fst, hit, uf, af, pf, chg;
      int          s, lim;
      longint      dl, lost, sm;
      logic [31:0] diff;
      any  = en_u | en_a | en_p;
      s    = (rate < 1) ? 1 : (rate > 13) ? 13 : int'(rate);
      fst  = en_p && (s > 6);
      dl   = fst ? (256 * 64) / (64'd1 << s) : 256;
      diff = now - m_cmp;
      hit  = m_armed && any && m_prev_any && !diff[31];
      lost = longint'(diff) / dl;
      lim  = fst ? 1 : 64 / (1 << s);
      sm   = m_pcnt + lost + 1;
      chg  = !m_seen || (sec != m_psec);
      uf   = hit && en_u && chg && m_seen;
      af   = hit && en_a && hr == ahr && mn == amn && sec == asec;
      pf   = hit && en_p && (sm >= lim);
      e_tick = hit;
      e_irq  = uf | af | pf;
      if (hit) e_word = e_irq ? {8'd1, 1'b1, pf, af, uf, 4'd0} : 16'd0;
      if (!en_p) m_pcnt = 0;
      else if (hit) m_pcnt = pf ? 0 : sm;
      if (!en_u) m_seen = 1'b0;
      else if (hit && chg) begin m_seen = 1'b1; m_psec = sec; end
      if (!any) m_armed = 1'b0;
      else if (!m_prev_any) begin m_armed = 1'b1; m_cmp = now + 32'(dl); end
      else if (hit) m_cmp = m_cmp + 32'((lost + 1) * dl);
      m_prev_any = any;
   endtask

   // one clock: model predicts, DUT samples at posedge, compare 1 ns later
   task automatic cyc();
      model_step();
      @(posedge clk);
      #1;
      chk(tick === e_tick, "R2 tick_o", 32'(tick), 32'(e_tick));
      chk(irq === e_irq, "R10 irq_o", 32'(irq), 32'(e_irq));
      chk(word === e_word, "R9 flag_word_o", 32'(word), 32'(e_word));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      now = 32'd1000;
      repeat (3) @(posedge clk);
      #1;
      // R1
      chk(word == 16'd0 && !irq && !tick, "R1 reset state", {word, 14'd0, irq, tick}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      cyc();
      // directed: update first-record and catch-up
      en_u = 1'b1; cyc();
      now = 32'd1255; cyc();
      chk(tick == 1'b0, "R2 no tick one count early", 32'(tick), 32'd0);
      now = 32'd1256; cyc();
      chk(tick == 1'b1 && irq == 1'b0, "R7 first tick only records", {tick, irq}, 32'h2);
      sec = 6'd6; now = 32'd1512; cyc();
      chk(word == 16'h0190, "R7 update flag", 32'(word), 32'h0190);
      now = 32'd2280; cyc();
      chk(tick == 1'b1 && word == 16'h0000, "R9 eventless tick clears", 32'(word), 32'd0);
      now = 32'd2535; cyc();
      chk(tick == 1'b0, "R4 catch-up skips two", 32'(tick), 32'd0);
      now = 32'd2536; cyc();
      chk(tick == 1'b1, "R4 next compare point", 32'(tick), 32'd1);
      // alarm
      ahr = 5'd1; amn = 6'd2; asec = 6'd6; en_a = 1'b1; cyc();
      now = 32'd2792; cyc();
      chk(word == 16'h01A0 && irq, "R8 alarm match", 32'(word), 32'h01A0);
      now = 32'd2793; cyc();
      chk(!irq && word == 16'h01A0, "R10 strobe one cycle", {irq, word}, 32'h01A0);
      // all off
      en_u = 1'b0; en_a = 1'b0; now = 32'd3048; cyc();
      chk(tick == 1'b0 && word == 16'h01A0, "R11 idle no tick", {tick, word}, 32'h01A0);
      now = 32'd5000; cyc();
      chk(tick == 1'b0, "R11 idle far count", 32'(tick), 32'd0);
      en_p = 1'b1; rate = 4'd6; cyc();
      now = 32'd5255; cyc();
      chk(tick == 1'b0, "R11 restart from current count", 32'(tick), 32'd0);
      now = 32'd5256; cyc();
      chk(word == 16'h01C0, "R5 64 Hz every tick", 32'(word), 32'h01C0);
      // fast rate
      rate = 4'd13; now = 32'd5511; cyc();
      now = 32'd5512; cyc();
      chk(word == 16'h01C0 && tick, "R6 fast periodic", 32'(word), 32'h01C0);
      now = 32'd5513; cyc();
      chk(tick == 1'b0, "R3 fast interval", 32'(tick), 32'd0);
      now = 32'd5514; cyc();
      chk(tick == 1'b1, "R3 fast interval two counts", 32'(tick), 32'd1);
      now = 32'd5515; cyc();
      now = 32'd5516; cyc();
      // slow 16 Hz: divide by 4 with lost ticks
      rate = 4'd4; now = 32'd5517; cyc();
      now = 32'd5518; cyc();
      chk(tick && word == 16'd0, "R5 divider count 1", 32'(word), 32'd0);
      now = 32'd6030; cyc();
      chk(tick && word == 16'd0, "R5 lost tick adds", 32'(word), 32'd0);
      now = 32'd6286; cyc();
      chk(word == 16'h01C0, "R5 divider reaches limit", 32'(word), 32'h01C0);
      rate = 4'd15; now = 32'd6300; cyc();
      now = 32'd6542; cyc();
      chk(tick == 1'b1, "R3 code above 13 clamps", 32'(tick), 32'd1);
      // random phase, starting near wrap
      en_p = 1'b0; cyc();
      now = 32'hFFFF_8000;
      for (int i = 0; i < 20000; i++) begin
         if ($urandom_range(0, 299) == 0) en_u = ~en_u;
         if ($urandom_range(0, 299) == 0) en_a = ~en_a;
         if ($urandom_range(0, 299) == 0) en_p = ~en_p;
         if ($urandom_range(0, 199) == 0) rate = 4'($urandom_range(0, 15));
         if ($urandom_range(0, 59) == 0) sec = 6'($urandom_range(0, 3));
         if ($urandom_range(0, 99) == 0) hr = 5'($urandom_range(1, 2));
         if ($urandom_range(0, 99) == 0) mn = 6'($urandom_range(2, 3));
         if ($urandom_range(0, 499) == 0) begin
            ahr = 5'($urandom_range(1, 2));
            amn = 6'($urandom_range(2, 3));
            asec = 6'($urandom_range(0, 3));
         end
         if ($urandom_range(0, 299) == 0) now = now + 32'($urandom_range(300, 3000));
         else now = now + 32'($urandom_range(0, 7));
         cyc();
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule